// File: doc/BRIEF.md
# Shift-and-Add Twiddle Rotator

This unit rotates one complex sample (x, y) per clock by a twiddle factor. Multipliers are not used. The rotation is written as two real coefficients: a cosine-like coefficient A and a sine-like coefficient B. Each coefficient is a short sum of signed power-of-two terms, so every product reduces to arithmetic right shifts followed by additions and subtractions.

The coefficient terms are chosen so that the overall gain A² + B² stays close to one. Because of this, the result leaves the unit without any gain-correction stage. A companion coefficient store, outside this block, supplies the parameter word with each sample. A single direction input conjugates the twiddle, so the same parameter word can serve both the forward and the inverse transform.

The datapath has two register levels:
- **Shift level:** a barrel-shifter array for x and another for y produce every shifted term.
- **Combine level:** four add/subtract operations merge those terms, saturate the results to the data width and register them.

A valid flag travels alongside the data through both levels.

Top module: `msr_twiddle_rotator`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `out_valid` is 0 and `out_x` and `out_y` are 0.
- R2: An accepted sample (`in_valid` high at a rising edge) appears with `out_valid` high exactly two rising edges later. Samples may arrive on every cycle, and each one produces exactly one result, in order.
- R3: The parameter word is 18 bits long and holds three 6-bit terms. Term k occupies bits [6k+5:6k]. Within a term, bits [3:0] are the right-shift amount s (0 to 15) and bits [5:4] are the sign code. The sign codes are: 01 = +1, 11 = −1, 00 or 10 = 0. Term 0 forms A; terms 1 and 2 form B.
- R4: With `in_inverse` low, the unit computes `out_x` = ΣA μ·(x>>>s) − ΣB μ·(y>>>s) and `out_y` = ΣB μ·(x>>>s) + ΣA μ·(y>>>s). Here >>> is an arithmetic shift that rounds toward minus infinity, and no gain correction is applied. For example, parameter 18'h00010 returns the input unchanged.
- R5: A term whose sign code is 00 or 10 contributes nothing, whatever its shift amount.
- R6: Each result that lies outside [−32768, 32767] is clamped to the nearer limit.
- R7: With `in_inverse` high, the sign of every B term is negated before use, which conjugates the twiddle. The A term is left unchanged.
- R8: In a cycle where `out_valid` is low, `out_x` and `out_y` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample and parameter word are present |
| in_x | input | 16 | Real part of the sample, two's complement |
| in_y | input | 16 | Imaginary part of the sample, two's complement |
| in_param | input | 18 | Three shift/sign terms that encode the twiddle |
| in_inverse | input | 1 | 1 = conjugate the twiddle (inverse transform) |
| out_valid | output | 1 | Rotated sample is present |
| out_x | output | 16 | Rotated real part, saturated |
| out_y | output | 16 | Rotated imaginary part, saturated |

## Verification
The bench drives a model of the requirements and compares every result against it. The following patterns each isolate one part of the behaviour:
- **Identity parameter:** checks that no hidden gain is applied.
- **Zero-code terms with nonzero shifts:** checks that the reserved and zero codes are truly inert.
- **Single negative B term at shift 0, with and without inversion:** separates the two cross-term signs, which shows whether the conjugation acts only on B.
- **Full-scale equal and opposite operands:** drives the sums past both limits.
- **Negative odd values at large shifts:** expose the rounding direction of the shifts.
- **Back-to-back pseudo-random parameter words:** stress throughput and ordering.
- **Idle gaps between bursts:** check that the outputs hold their values.

// File: rtl/msr_pkg.sv
package msr_pkg;

    typedef enum logic [1:0] {
        TERM_OFF = 2'b00,
        TERM_POS = 2'b01,
        TERM_RSV = 2'b10,
        TERM_NEG = 2'b11
    } term_sign_e;

    // Conjugation flips +1 and -1; inert codes stay inert.
    function automatic logic [1:0] flip_sign(input logic [1:0] code, input logic flip);
        logic [1:0] res;
        res = code;
        if (flip && code[0]) begin
            res = code ^ 2'b10;
        end
        return res;
    endfunction

endpackage

// File: rtl/msr_shift_array.sv
module msr_shift_array #(
    parameter int DATA_W  = 16,
    parameter int SHIFT_W = 4,
    parameter int NSPT    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [DATA_W-1:0]        din,
    input  logic [NSPT*SHIFT_W-1:0]  shifts,
    output logic [NSPT*DATA_W-1:0]   terms
);

    genvar k;
    generate
        for (k = 0; k < NSPT; k++) begin : g_term
            logic [SHIFT_W-1:0] amt;
            logic [DATA_W-1:0]  shifted;

            assign amt     = shifts[k*SHIFT_W +: SHIFT_W];
            assign shifted = DATA_W'($signed(din) >>> amt);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    terms[k*DATA_W +: DATA_W] <= '0;
                end else if (en) begin
                    terms[k*DATA_W +: DATA_W] <= shifted;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/msr_term_combine.sv
module msr_term_combine
    import msr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NSPT    = 3,
    parameter int A_TERMS = 1,
    parameter int ACC_W   = 19
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [NSPT*DATA_W-1:0] x_terms,
    input  logic [NSPT*DATA_W-1:0] y_terms,
    input  logic [NSPT*2-1:0]      signs,
    output logic [DATA_W-1:0]      rot_x,
    output logic [DATA_W-1:0]      rot_y
);

    localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((1 << (DATA_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] MIN_V = -ACC_W'(1 << (DATA_W-1));

    logic signed [ACC_W-1:0] acc_x;
    logic signed [ACC_W-1:0] acc_y;
    logic [DATA_W-1:0]       sat_x;
    logic [DATA_W-1:0]       sat_y;

    always_comb begin
        acc_x = '0;
        acc_y = '0;
        for (int k = 0; k < NSPT; k++) begin
            logic signed [ACC_W-1:0] tx;
            logic signed [ACC_W-1:0] ty;
            term_sign_e              code;
            tx   = ACC_W'($signed(x_terms[k*DATA_W +: DATA_W]));
            ty   = ACC_W'($signed(y_terms[k*DATA_W +: DATA_W]));
            code = term_sign_e'(signs[k*2 +: 2]);
            if (k < A_TERMS) begin
                unique case (code)
                    TERM_POS: begin acc_x = acc_x + tx; acc_y = acc_y + ty; end
                    TERM_NEG: begin acc_x = acc_x - tx; acc_y = acc_y - ty; end
                    default:  ;
                endcase
            end else begin
                unique case (code)
                    TERM_POS: begin acc_x = acc_x - ty; acc_y = acc_y + tx; end
                    TERM_NEG: begin acc_x = acc_x + ty; acc_y = acc_y - tx; end
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        if (acc_x > MAX_V)      sat_x = MAX_V[DATA_W-1:0];
        else if (acc_x < MIN_V) sat_x = MIN_V[DATA_W-1:0];
        else                    sat_x = acc_x[DATA_W-1:0];
        if (acc_y > MAX_V)      sat_y = MAX_V[DATA_W-1:0];
        else if (acc_y < MIN_V) sat_y = MIN_V[DATA_W-1:0];
        else                    sat_y = acc_y[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rot_x <= '0;
            rot_y <= '0;
        end else if (en) begin
            rot_x <= sat_x;
            rot_y <= sat_y;
        end
    end

endmodule

// File: rtl/msr_twiddle_rotator.sv
module msr_twiddle_rotator
    import msr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SHIFT_W = 4,
    parameter int A_TERMS = 1,
    parameter int B_TERMS = 2,
    localparam int NSPT    = A_TERMS + B_TERMS,
    localparam int TERM_W  = 2 + SHIFT_W,
    localparam int PARAM_W = NSPT * TERM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_x,
    input  logic [DATA_W-1:0]  in_y,
    input  logic [PARAM_W-1:0] in_param,
    input  logic               in_inverse,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_x,
    output logic [DATA_W-1:0]  out_y
);

    localparam int ACC_W = DATA_W + $clog2(NSPT) + 1;

    logic [NSPT*SHIFT_W-1:0] shift_fld;
    logic [NSPT*2-1:0]       sign_fld;
    logic [NSPT*2-1:0]       sign_q;
    logic [NSPT*DATA_W-1:0]  x_terms;
    logic [NSPT*DATA_W-1:0]  y_terms;
    logic                    vld_s1;
    logic                    vld_s2;

    genvar k;
    generate
        for (k = 0; k < NSPT; k++) begin : g_split
            assign shift_fld[k*SHIFT_W +: SHIFT_W] = in_param[k*TERM_W +: SHIFT_W];
            assign sign_fld[k*2 +: 2] =
                flip_sign(in_param[k*TERM_W + SHIFT_W +: 2], in_inverse && (k >= A_TERMS));
        end
    endgenerate

    msr_shift_array #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .NSPT(NSPT)) u_bsa_x (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .din(in_x), .shifts(shift_fld), .terms(x_terms)
    );

    msr_shift_array #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .NSPT(NSPT)) u_bsa_y (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .din(in_y), .shifts(shift_fld), .terms(y_terms)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_q <= '0;
            vld_s1 <= 1'b0;
            vld_s2 <= 1'b0;
        end else begin
            vld_s1 <= in_valid;
            vld_s2 <= vld_s1;
            if (in_valid) begin
                sign_q <= sign_fld;
            end
        end
    end

    msr_term_combine #(.DATA_W(DATA_W), .NSPT(NSPT), .A_TERMS(A_TERMS), .ACC_W(ACC_W)) u_comb (
        .clk(clk), .rst_n(rst_n), .en(vld_s1), .x_terms(x_terms), .y_terms(y_terms),
        .signs(sign_q), .rot_x(out_x), .rot_y(out_y)
    );

    assign out_valid = vld_s2;

endmodule

// File: rtl/msr_twiddle_rotator_chk.sv
module msr_twiddle_rotator_chk #(
    parameter int DATA_W  = 16,
    parameter int SHIFT_W = 4,
    parameter int PARAM_W = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [DATA_W-1:0]  in_x,
    input logic [DATA_W-1:0]  in_y,
    input logic [PARAM_W-1:0] in_param,
    input logic               in_inverse,
    input logic               out_valid,
    input logic [DATA_W-1:0]  out_x,
    input logic [DATA_W-1:0]  out_y
);

    localparam logic [PARAM_W-1:0] IDENT_P = PARAM_W'({2'b01, {SHIFT_W{1'b0}}});

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && out_x == '0 && out_y == '0)); // R1

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid); // R2

    AST_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_param == IDENT_P) |-> ##2
        (out_x == $past(in_x, 2) && out_y == $past(in_y, 2))); // R4

    AST_INERT_TERMS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_param == '0) |-> ##2 (out_x == '0 && out_y == '0)); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_x) && $stable(out_y))); // R8

endmodule

bind msr_twiddle_rotator msr_twiddle_rotator_chk #(
    .DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .PARAM_W(PARAM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_param(in_param), .in_inverse(in_inverse), .out_valid(out_valid),
    .out_x(out_x), .out_y(out_y)
);

// File: tb/msr_twiddle_rotator_bench.sv
module msr_twiddle_rotator_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_x = '0;
    logic [15:0] in_y = '0;
    logic [17:0] in_param = '0;
    logic        in_inverse = 1'b0;
    logic        out_valid;
    logic [15:0] out_x;
    logic [15:0] out_y;

    always #10 clk = ~clk;

    msr_twiddle_rotator u_msr_twiddle_rotator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_param(in_param), .in_inverse(in_inverse), .out_valid(out_valid),
        .out_x(out_x), .out_y(out_y)
    );

    typedef struct {
        logic [15:0] ex;
        logic [15:0] ey;
        int          cyc;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          n_vec = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          mon_on = 1'b0;
    bit          done = 1'b0;
    bit          have_prev = 1'b0;
    logic [15:0] prev_x;
    logic [15:0] prev_y;
    logic [31:0] lcg = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Reference from R3..R7
    function automatic logic [31:0] model(input logic [15:0] x, input logic [15:0] y,
                                          input logic [17:0] p, input bit inv);
        int xi = int'($signed(x));
        int yi = int'($signed(y));
        int rx = 0;
        int ry = 0;
        for (int k = 0; k < 3; k++) begin
            logic [1:0] sc = p[6*k+4 +: 2];
            int sh = int'(p[6*k +: 4]);
            int mu = (sc == 2'b01) ? 1 : (sc == 2'b11) ? -1 : 0;
            int tx = xi >>> sh;
            int ty = yi >>> sh;
            if (k >= 1 && inv) mu = -mu;
            if (k == 0) begin
                rx += mu * tx; ry += mu * ty;
            end else begin
                rx -= mu * ty; ry += mu * tx;
            end
        end
        return {16'(sat16(rx)), 16'(sat16(ry))};
    endfunction

    function automatic logic [17:0] mk(input logic [1:0] s0, input int h0,
                                       input logic [1:0] s1, input int h1,
                                       input logic [1:0] s2, input int h2);
        return {s2, 4'(h2), s1, 4'(h1), s0, 4'(h0)};
    endfunction

    task automatic send(input logic [15:0] x, input logic [15:0] y,
                        input logic [17:0] p, input bit inv, input string req);
        exp_t        e;
        logic [31:0] m;
        @(negedge clk);
        in_valid   = 1'b1;
        in_x       = x;
        in_y       = y;
        in_param   = p;
        in_inverse = inv;
        m     = model(x, y, p, inv);
        e.ex  = m[31:16];
        e.ey  = m[15:0];
        e.cyc = cyc;
        e.req = req;
        sb.push_back(e);
        n_vec++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_x     = 16'hDEAD;
            in_param = 18'h3FFFF;
        end
    endtask

    // Monitor: pop and compare
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_x == e.ex, e.req, "out_x", longint'($signed(out_x)), longint'($signed(e.ex)));
                    check(out_y == e.ey, e.req, "out_y", longint'($signed(out_y)), longint'($signed(e.ey)));
                    check(cyc == e.cyc + 2, "R2", "latency", cyc - e.cyc, 2);
                end
                prev_x    = out_x;
                prev_y    = out_y;
                have_prev = 1'b1;
            end else if (have_prev) begin
                check(out_x == prev_x && out_y == prev_y, "R8", "hold",
                      longint'(out_x), longint'(prev_x));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        check(out_x == 16'd0 && out_y == 16'd0, "R1", "reset data", out_x, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "post-reset out_valid", out_valid, 0);
        mon_on = 1'b1;

        // R4 identity, no gain correction
        send(16'd1234, -16'sd567, 18'h00010, 1'b0, "R4");
        send(16'h8000, 16'h7FFF, 18'h00010, 1'b0, "R4");
        idle(3);
        // R4 rounding toward minus infinity on negative odd values
        send(-16'sd7, -16'sd1, mk(2'b01, 1, 2'b00, 0, 2'b00, 0), 1'b0, "R4");
        send(-16'sd32767, 16'sd5, mk(2'b11, 15, 2'b01, 14, 2'b00, 0), 1'b0, "R4");
        // R3 term placement: single B term, negative, shift 0
        send(16'd100, 16'd40, mk(2'b00, 0, 2'b11, 0, 2'b00, 0), 1'b0, "R3");
        send(16'd100, 16'd40, mk(2'b00, 0, 2'b00, 0, 2'b01, 2), 1'b0, "R3");
        // R5 inert codes with nonzero shifts
        send(16'd9999, -16'sd4444, mk(2'b10, 3, 2'b00, 7, 2'b10, 15), 1'b0, "R5");
        send(16'd9999, -16'sd4444, 18'h00000, 1'b1, "R5");
        send(16'd512, 16'd256, mk(2'b01, 1, 2'b10, 0, 2'b00, 5), 1'b0, "R5");
        idle(2);
        // R6 saturation both directions
        send(16'd30000, 16'd30000, mk(2'b01, 0, 2'b11, 0, 2'b00, 0), 1'b0, "R6");
        send(-16'sd30000, -16'sd30000, mk(2'b01, 0, 2'b11, 0, 2'b00, 0), 1'b0, "R6");
        send(16'd20000, -16'sd20000, mk(2'b01, 0, 2'b01, 0, 2'b01, 0), 1'b0, "R6");
        send(16'h8000, 16'h8000, mk(2'b11, 0, 2'b00, 0, 2'b00, 0), 1'b0, "R6");
        // R7 inverse conjugates only B
        send(16'd100, 16'd40, mk(2'b00, 0, 2'b11, 0, 2'b00, 0), 1'b1, "R7");
        send(16'd3000, -16'sd2000, mk(2'b11, 1, 2'b01, 2, 2'b10, 3), 1'b1, "R7");
        send(16'h8000, 16'd1, mk(2'b00, 0, 2'b01, 0, 2'b00, 0), 1'b1, "R7");
        idle(4);
        // R2 back-to-back pseudo-random stream
        for (int i = 0; i < 80; i++) begin
            logic [15:0] rx;
            logic [15:0] ry;
            logic [17:0] rp;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            rx  = lcg[31:16];
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            ry  = lcg[31:16];
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            rp  = lcg[31:14];
            send(rx, ry, rp, lcg[3], (i % 2 == 0) ? "R2" : "R4");
            if (i % 17 == 16) idle(3);
        end
        idle(6);
        check(sb.size() == 0, "R2", "results outstanding", sb.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule